// File: doc/BRIEF.md
# Serial DAC Input Register Front End

This block is the digital side of a 16-bit serial digital-to-analog converter. A host drives three lines: an active-low frame select, a serial clock and a serial data line. While frame select is low, the block samples one data bit on every falling serial-clock edge and fills a 24-bit input register, most significant bit first. When the twenty-fourth bit arrives, it loads the 16-bit conversion code and the 2-bit power-down mode in the same cycle. If frame select rises before then, the partial frame is thrown away and nothing changes.

All logic runs on a system clock that is much faster than the serial clock. The three serial lines pass through two-flop synchronizers, and serial-clock falling edges are found in the system-clock domain. The host writes the code in two's complement. The block hands it on to the analog side as offset binary, and it also gives one strobe for each non-normal output termination.

Top module: `sdac_frontend`

## Requirements
- R1: After reset, `code_o` is 0x8000 (midscale), `mode_o` is 00 and all three termination strobes are low. These values hold until a complete frame is received.
- R2: A frame is 24 bits, sent MSB first, one bit per falling serial-clock edge while frame select is low. Frame bits 15..0 are the data word, bits 17..16 are the power-down field, and bits 23..18 have no effect on any output.
- R3: Outputs change only after the 24th falling edge of a frame. After 23 edges, code and mode are still unchanged.
- R4: If frame select goes high before the 24th falling edge, code and mode keep their previous values. The next full frame is then received correctly from its first bit.
- R5: Falling serial-clock edges after the 24th one, while frame select stays low, have no effect on code or mode.
- R6: A new frame starts only after frame select goes high and then low again.
- R7: `code_o` equals the received two's-complement data word with bit 15 inverted. So 0x0000 gives 0x8000, 0x7FFF gives 0xFFFF, 0x8000 gives 0x0000 and 0xFFFF gives 0x7FFF.
- R8: The power-down field is decoded as follows: 00 is normal with no strobe, 01 raises `term_1k_o`, 10 raises `term_100k_o` and 11 raises `term_open_o`. At most one strobe is high at any time.
- R9: Code and mode are loaded together by the same valid frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System (oversampling) clock |
| rst | input | 1 | Synchronous active-high reset |
| fsel_n_i | input | 1 | Frame select, active low, asynchronous |
| sclk_i | input | 1 | Serial clock, data sampled on falling edge |
| sdin_i | input | 1 | Serial data, MSB first |
| code_o | output | 16 | Current code, offset binary |
| mode_o | output | 2 | Current power-down field |
| term_1k_o | output | 1 | Output tied to ground through 1 kΩ |
| term_100k_o | output | 1 | Output tied to ground through 100 kΩ |
| term_open_o | output | 1 | Output high impedance |

## Verification
The bench aborts frames after 23 bits and after 10 bits. A receiver that does not clear its counter on abort would finish a frame early on the next write and load misaligned bits. One that loads on the wrong edge count would show a changed code right after edge 23. The bench then sends 48 edges in one low frame-select window. A design that wraps its counter instead of waiting for frame select to rise would overwrite the code with the trailing 24 bits. The bench also checks the extremes of the data range and sets the spare bits to ones, which catches an unflipped or wrongly flipped sign bit and spare bits leaking into the mode field.

// File: rtl/sdac_pkg.sv
package sdac_pkg;

    localparam int FRAME_BITS = 24;
    localparam int WORD_W     = 16;
    localparam int MODE_W     = 2;
    localparam int SPARE_W    = FRAME_BITS - WORD_W - MODE_W;
    localparam int CNT_W      = $clog2(FRAME_BITS + 1);
    localparam int N_TERM     = (1 << MODE_W) - 1;

    typedef enum logic [MODE_W-1:0] {
        PD_NORMAL   = 2'b00,
        PD_GND_1K   = 2'b01,
        PD_GND_100K = 2'b10,
        PD_OPEN     = 2'b11
    } pd_mode_e;

    typedef struct packed {
        logic [SPARE_W-1:0] spare;
        pd_mode_e           mode;
        logic [WORD_W-1:0]  word;
    } frame_t;

    typedef enum logic [1:0] {
        RX_WAIT_HI,
        RX_ARMED,
        RX_SHIFT,
        RX_DONE
    } rx_state_e;

    // two's complement -> offset binary: flip the sign bit
    function automatic logic [WORD_W-1:0] to_offset_bin(input logic [WORD_W-1:0] tc);
        return {~tc[WORD_W-1], tc[WORD_W-2:0]};
    endfunction

endpackage

// File: rtl/sdac_sync.sv
module sdac_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (rst) chain <= RST_VAL;
                else     chain <= d;
            end
        end else begin : g_many
            always_ff @(posedge clk) begin
                if (rst) chain <= {STAGES{RST_VAL}};
                else     chain <= {chain[STAGES-2:0], d};
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/sdac_frame_rx.sv
module sdac_frame_rx
    import sdac_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   sel_s,     // synchronized frame select (active low)
    input  logic   sclk_s,    // synchronized serial clock
    input  logic   din_s,     // synchronized serial data
    output logic   frame_vld, // one-cycle pulse on completed frame
    output frame_t frame
);
    rx_state_e             state_q;
    logic [CNT_W-1:0]      cnt_q;
    logic [FRAME_BITS-1:0] sh_q;
    logic                  sclk_prev_q;
    logic                  sclk_fall;
    logic [FRAME_BITS-1:0] sh_next;

    assign sclk_fall = sclk_prev_q & ~sclk_s;
    assign sh_next   = {sh_q[FRAME_BITS-2:0], din_s};

    always_ff @(posedge clk) begin
        if (rst) sclk_prev_q <= 1'b1;
        else     sclk_prev_q <= sclk_s;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= RX_WAIT_HI;
            cnt_q     <= '0;
            sh_q      <= '0;
            frame_vld <= 1'b0;
            frame     <= '0;
        end else begin
            frame_vld <= 1'b0;
            unique case (state_q)
                RX_WAIT_HI: begin
                    if (sel_s) state_q <= RX_ARMED;
                end
                RX_ARMED: begin
                    if (!sel_s) begin
                        state_q <= RX_SHIFT;
                        cnt_q   <= '0;
                        sh_q    <= '0;
                    end
                end
                RX_SHIFT: begin
                    if (sel_s) begin
                        state_q <= RX_ARMED;
                        cnt_q   <= '0;
                        sh_q    <= '0;
                    end else if (sclk_fall) begin
                        sh_q  <= sh_next;
                        cnt_q <= cnt_q + 1'b1;
                        if (cnt_q == CNT_W'(FRAME_BITS - 1)) begin
                            frame_vld <= 1'b1;
                            frame     <= frame_t'(sh_next);
                            state_q   <= RX_DONE;
                        end
                    end
                end
                RX_DONE: begin
                    if (sel_s) begin
                        state_q <= RX_ARMED;
                        cnt_q   <= '0;
                        sh_q    <= '0;
                    end
                end
                default: state_q <= RX_WAIT_HI;
            endcase
        end
    end

    p_cnt_bound_r3: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= CNT_W'(FRAME_BITS));

    p_vld_at_full_r3: assert property (@(posedge clk) disable iff (rst)
        frame_vld |-> (cnt_q == CNT_W'(FRAME_BITS)) && (state_q == RX_DONE));

    p_abort_clears_r4: assert property (@(posedge clk) disable iff (rst)
        (state_q == RX_SHIFT && sel_s) |=> (cnt_q == '0) && !frame_vld && (state_q == RX_ARMED));

    p_done_holds_r5: assert property (@(posedge clk) disable iff (rst)
        (state_q == RX_DONE && !sel_s) |=> (state_q == RX_DONE) && !frame_vld);

    p_start_needs_high_r6: assert property (@(posedge clk) disable iff (rst)
        (state_q == RX_WAIT_HI || state_q == RX_DONE) |=> state_q != RX_SHIFT);

endmodule

// File: rtl/sdac_code_reg.sv
module sdac_code_reg
    import sdac_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              frame_vld,
    input  frame_t            frame,
    output logic [WORD_W-1:0] code_ob,
    output pd_mode_e          mode
);
    logic [WORD_W-1:0] word_q;   // two's complement, 0 = midscale
    pd_mode_e          mode_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            word_q <= '0;
            mode_q <= PD_NORMAL;
        end else if (frame_vld) begin
            word_q <= frame.word;
            mode_q <= frame.mode;
        end
    end

    assign code_ob = to_offset_bin(word_q);
    assign mode    = mode_q;

    p_hold_no_frame_r3: assert property (@(posedge clk) disable iff (rst)
        !frame_vld |=> $stable(word_q) && $stable(mode_q));

    p_load_together_r9: assert property (@(posedge clk) disable iff (rst)
        frame_vld |=> (word_q == $past(frame.word)) && (mode_q == $past(frame.mode)));

endmodule

// File: rtl/sdac_term_decode.sv
module sdac_term_decode
    import sdac_pkg::*;
(
    input  pd_mode_e          mode,
    output logic [N_TERM-1:0] strobe
);
    generate
        for (genvar g = 0; g < N_TERM; g++) begin : g_term
            assign strobe[g] = (mode == pd_mode_e'(g + 1));
        end
    endgenerate

    always_comb begin
        p_one_strobe_r8: assert ($onehot0(strobe));
        p_normal_quiet_r8: assert ((mode == PD_NORMAL) == (strobe == '0));
    end
endmodule

// File: rtl/sdac_frontend.sv
module sdac_frontend
    import sdac_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        fsel_n_i,
    input  logic        sclk_i,
    input  logic        sdin_i,
    output logic [15:0] code_o,
    output logic [1:0]  mode_o,
    output logic        term_1k_o,
    output logic        term_100k_o,
    output logic        term_open_o
);
    localparam int SYNC_STAGES = 2;

    logic              sel_s, sclk_s, din_s;
    logic              frame_vld;
    frame_t            frame;
    logic [WORD_W-1:0] code_ob;
    pd_mode_e          mode;
    logic [N_TERM-1:0] strobe;

    sdac_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_sel (
        .clk(clk), .rst(rst), .d(fsel_n_i), .q(sel_s));
    sdac_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_sclk (
        .clk(clk), .rst(rst), .d(sclk_i), .q(sclk_s));
    sdac_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_din (
        .clk(clk), .rst(rst), .d(sdin_i), .q(din_s));

    sdac_frame_rx u_rx (
        .clk(clk), .rst(rst), .sel_s(sel_s), .sclk_s(sclk_s), .din_s(din_s),
        .frame_vld(frame_vld), .frame(frame));

    sdac_code_reg u_reg (
        .clk(clk), .rst(rst), .frame_vld(frame_vld), .frame(frame),
        .code_ob(code_ob), .mode(mode));

    sdac_term_decode u_dec (.mode(mode), .strobe(strobe));

    assign code_o      = code_ob;
    assign mode_o      = mode;
    assign term_1k_o   = strobe[0];
    assign term_100k_o = strobe[1];
    assign term_open_o = strobe[2];

    p_offset_code_r7: assert property (@(posedge clk) disable iff (rst)
        frame_vld |=> code_o == {~$past(frame.word[WORD_W-1]), $past(frame.word[WORD_W-2:0])});

    p_mode_out_r2: assert property (@(posedge clk) disable iff (rst)
        frame_vld |=> mode_o == $past(frame.mode));

endmodule

// File: tb/sdac_frontend_tb.sv
module sdac_frontend_tb;
    localparam int CLK_PERIOD = 10;
    localparam int HALF_SCLK  = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic fsel_n = 1'b1;
    logic sclk = 1'b1;
    logic sdin = 1'b0;
    logic [15:0] code_o;
    logic [1:0]  mode_o;
    logic term_1k_o, term_100k_o, term_open_o;

    always #(CLK_PERIOD/2) clk = ~clk;

    sdac_frontend u_dut (
        .clk(clk), .rst(rst), .fsel_n_i(fsel_n), .sclk_i(sclk), .sdin_i(sdin),
        .code_o(code_o), .mode_o(mode_o), .term_1k_o(term_1k_o),
        .term_100k_o(term_100k_o), .term_open_o(term_open_o));

    typedef struct {
        logic [15:0] code;
        logic [1:0]  mode;
        string       req;
    } exp_t;

    exp_t q[$];
    int total = 0;
    int bad = 0;
    bit finished = 1'b0;
    logic [15:0] cur_code = 16'h8000;
    logic [1:0]  cur_mode = 2'b00;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic check_outputs(input logic [15:0] ec, input logic [1:0] em, input string req);
        logic [2:0] es;
        es = {em == 2'b11, em == 2'b10, em == 2'b01};
        chk(code_o == ec, req, 32'(code_o), 32'(ec));
        chk(mode_o == em, req, 32'(mode_o), 32'(em));
        chk({term_open_o, term_100k_o, term_1k_o} == es, req,
            32'({term_open_o, term_100k_o, term_1k_o}), 32'(es));
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(posedge clk);
    endtask

    task automatic shift_bits(input logic [47:0] bits, input int n);
        for (int i = 0; i < n; i++) begin
            sdin = bits[47-i];
            wait_clk(HALF_SCLK);
            sclk = 1'b0;
            wait_clk(HALF_SCLK);
            sclk = 1'b1;
        end
    endtask

    task automatic open_frame();
        fsel_n = 1'b1;
        wait_clk(4);
        fsel_n = 1'b0;
        wait_clk(4);
    endtask

    task automatic push(input string req);
        exp_t e;
        e.code = cur_code;
        e.mode = cur_mode;
        e.req  = req;
        q.push_back(e);
        wait_clk(12);
    endtask

    // full valid frame: spare, mode, two's complement data
    task automatic write_frame(input logic [5:0] spare, input logic [1:0] md,
                               input logic [15:0] data, input string req);
        open_frame();
        shift_bits({spare, md, data, 24'h0}, 24);
        fsel_n = 1'b1;
        cur_code = data ^ 16'h8000;
        cur_mode = md;
        push(req);
    endtask

    // monitor
    initial begin
        forever begin
            wait (q.size() > 0);
            repeat (6) @(negedge clk);
            begin
                exp_t e;
                e = q.pop_front();
                check_outputs(e.code, e.mode, e.req);
            end
        end
    end

    // watchdog
    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    // driver
    initial begin
        wait_clk(5);
        rst = 1'b0;
        @(negedge clk);
        check_outputs(16'h8000, 2'b00, "R1 reset state");
        wait_clk(3);

        write_frame(6'h3F, 2'b00, 16'h1234, "R2 frame layout, spare ones");
        write_frame(6'h00, 2'b01, 16'h8000, "R7 min code / R8 1k");
        write_frame(6'h15, 2'b10, 16'h7FFF, "R7 max code / R8 100k");
        write_frame(6'h2A, 2'b11, 16'hFFFF, "R7 minus one / R8 open / R9");

        // R3: 23 edges, nothing yet; then abort (R4)
        open_frame();
        shift_bits({6'h0, 2'b01, 16'h0001, 24'h0}, 23);
        wait_clk(8);
        @(negedge clk);
        check_outputs(cur_code, cur_mode, "R3 no update after 23 edges");
        fsel_n = 1'b1;
        push("R4 abort at 23 edges");

        // R4: abort after 10 bits, then a clean frame
        open_frame();
        shift_bits({24'hFFFFFF, 24'h0}, 10);
        fsel_n = 1'b1;
        push("R4 abort at 10 edges");
        write_frame(6'h00, 2'b10, 16'hA5C3, "R4 frame after abort");

        // R5/R6: 48 edges in one low window, trailing 24 ignored
        open_frame();
        shift_bits({6'h00, 2'b01, 16'h0F0F, 6'h3F, 2'b11, 16'h5555}, 48);
        cur_code = 16'h0F0F ^ 16'h8000;
        cur_mode = 2'b01;
        push("R5 edges after 24th ignored");
        fsel_n = 1'b0;
        shift_bits({24'hFFFFFF, 24'h0}, 24);
        push("R6 no new frame without select high");
        fsel_n = 1'b1;
        wait_clk(4);

        write_frame(6'h3F, 2'b00, 16'h0000, "R8 back to normal / R7 midscale");

        wait_clk(20);
        if (!finished) begin
            finished = 1'b1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule